// File: doc/BRIEF.md
# Cartridge ROM Bank-Switch Mapper

This block lets a CPU with a 13-bit address bus reach a 32 KB ROM through a 4 KB window. The ROM is split into 4 KB banks. When address bit 12 is high, the window is open and the low twelve address bits select a byte within the active bank. A small group of reserved addresses near the top of the window are hotspots. Any strobed access to a hotspot makes the bank that hotspot names the active bank. The direction of the access does not matter.

Cartridge hardware differs in when a hotspot access takes effect, and a parameter selects one of three behaviours. In switch-first mode the hotspot byte itself is fetched from the new bank. In fetch-first mode that byte comes from the old bank and the switch takes effect on the next access. In float mode the data bus is not driven for the hotspot access. A second parameter builds 2-bank, 4-bank or 8-bank variants, and a third sets the bank selected after reset. The ROM array and the CPU are outside this block. The block forms the ROM address and the data-bus output enable.

Top module: `cart_bank_mapper`

## Requirements
- R1: `rom_oe` is high only in a cycle where `acc_stb` is high and `cpu_a[12]` is high, and in that case it is high unless R8 applies.
- R2: Hotspots map to banks as follows, and no other address is a hotspot.
  - 8 banks: address 0x1FF4+n selects bank n, for n = 0 to 7.
  - 4 banks: addresses 0x1FF6 to 0x1FF9 select banks 0 to 3.
  - 2 banks: 0x1FF8 selects bank 0 and 0x1FF9 selects bank 1.
- R3: After reset, the active bank equals the parameter `RESET_BANK`.
- R4: In switch-first mode, a hotspot access is served from the newly selected bank within the same cycle.
- R5: In switch-first mode, a run of back-to-back strobed hotspot accesses is controlled by its first hotspot. Later hotspots in the run change nothing, and they are served from the bank the first hotspot selected.
- R6: In fetch-first mode, a hotspot access is served from the previously active bank, and the new bank applies from the next access onward.
- R7: In fetch-first mode, every access in a hotspot run is served from the bank that was active before the run. After the run, the bank named by the last hotspot is active.
- R8: In float mode, `rom_oe` is low for every hotspot access and the bank still switches. In a run of hotspots, the last one decides the bank.
- R9: The active bank does not change in a cycle where `acc_stb` is low, nor on a strobed access with `cpu_a[12]` low.
- R10: `rom_addr` is the serving bank number in bits 12 and up, followed by `cpu_a[11:0]` in bits 11:0. It is combinationally valid in the access cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| cpu_a | input | 13 | CPU address bus |
| acc_stb | input | 1 | High for one cycle per bus access |
| rom_addr | output | 12+log2(NUM_BANKS) | ROM byte address {bank, cpu_a[11:0]} |
| rom_oe | output | 1 | Enables the ROM data onto the bus |

## Verification
The bench builds four instances side by side. Two are 8-bank builds, one in switch-first mode and one in fetch-first mode, and they share a single stimulus table. This places the two run rules (first hotspot wins, and data held from the pre-run bank) next to each other on identical address streams. A 4-bank float-mode build with `RESET_BANK` = 3 covers a non-zero power-up bank, the disabled bus and last-wins runs. A 2-bank switch-first build covers the narrowest hotspot pair, including addresses that are hotspots only in wider variants.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [1:0] {
    SWITCH_FIRST = 2'd0,
    FETCH_FIRST  = 2'd1,
    FLOAT_BUS    = 2'd2
  } hot_mode_e;

  // Lowest hotspot offset inside the window for a given bank count
  function automatic logic [11:0] hot_base(input int unsigned nbanks);
    case (nbanks)
      2:       hot_base = 12'hFF8;
      4:       hot_base = 12'hFF6;
      default: hot_base = 12'hFF4;
    endcase
  endfunction

endpackage

// File: rtl/cart_rst_sync.sv
module cart_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/cart_hot_decode.sv
module cart_hot_decode
  import cart_map_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 3
) (
  input  logic [12:0]       cpu_a,
  output logic              hit,
  output logic [BANK_W-1:0] hit_bank
);
  localparam logic [11:0] BASE = hot_base(NUM_BANKS);

  logic [11:0] ofs;

  always_comb begin
    ofs      = cpu_a[11:0] - BASE;
    hit      = cpu_a[12] && (cpu_a[11:0] >= BASE) && (ofs < 12'(NUM_BANKS));
    hit_bank = ofs[BANK_W-1:0];
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_map_pkg::*;
#(
  parameter hot_mode_e   MODE       = SWITCH_FIRST,
  parameter int unsigned BANK_W     = 3,
  parameter int unsigned RESET_BANK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              hit,
  input  logic [BANK_W-1:0] hit_bank,
  output logic [BANK_W-1:0] serve_bank,
  output logic [BANK_W-1:0] bank_q,
  output logic              prev_hot_q
);
  logic [BANK_W-1:0] bank_d, run_q, run_d;
  logic              prev_hot_d;

  // next state and serving bank
  always_comb begin
    bank_d     = bank_q;
    run_d      = run_q;
    prev_hot_d = prev_hot_q;
    serve_bank = bank_q;
    if (acc_stb) begin
      prev_hot_d = hit;
      if (hit) begin
        case (MODE)
          SWITCH_FIRST: begin
            if (!prev_hot_q) begin
              bank_d     = hit_bank;
              serve_bank = hit_bank;
            end
          end
          FETCH_FIRST: begin
            bank_d = hit_bank;
            if (prev_hot_q) serve_bank = run_q;
            else            run_d      = bank_q;
          end
          default: bank_d = hit_bank;
        endcase
      end
    end
  end

  // registers, clock-enabled by the access strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q     <= BANK_W'(RESET_BANK);
      run_q      <= BANK_W'(RESET_BANK);
      prev_hot_q <= 1'b0;
    end else if (acc_stb) begin
      bank_q     <= bank_d;
      run_q      <= run_d;
      prev_hot_q <= prev_hot_d;
    end
  end
endmodule

// File: rtl/cart_bus_drive.sv
module cart_bus_drive
  import cart_map_pkg::*;
#(
  parameter hot_mode_e   MODE   = SWITCH_FIRST,
  parameter int unsigned BANK_W = 3
) (
  input  logic [12:0]        cpu_a,
  input  logic               acc_stb,
  input  logic               hit,
  input  logic [BANK_W-1:0]  serve_bank,
  output logic [BANK_W+11:0] rom_addr,
  output logic               rom_oe
);
  localparam logic FLOATS = (MODE == FLOAT_BUS);

  always_comb begin
    rom_addr = {serve_bank, cpu_a[11:0]};
    rom_oe   = acc_stb && cpu_a[12] && !(FLOATS && hit);
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 8,
  parameter hot_mode_e   MODE       = SWITCH_FIRST,
  parameter int unsigned RESET_BANK = 0,
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
  localparam int unsigned ROM_W     = 12 + BANK_W
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [12:0]      cpu_a,
  input  logic             acc_stb,
  output logic [ROM_W-1:0] rom_addr,
  output logic             rom_oe
);
  logic              rst_n;
  logic              hit;
  logic [BANK_W-1:0] hit_bank, serve_bank, bank_q;
  logic              prev_hot_q;

  cart_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  cart_hot_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
    .cpu_a(cpu_a), .hit(hit), .hit_bank(hit_bank)
  );

  cart_bank_ctrl #(.MODE(MODE), .BANK_W(BANK_W), .RESET_BANK(RESET_BANK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .hit(hit), .hit_bank(hit_bank),
    .serve_bank(serve_bank), .bank_q(bank_q), .prev_hot_q(prev_hot_q)
  );

  cart_bus_drive #(.MODE(MODE), .BANK_W(BANK_W)) u_drv (
    .cpu_a(cpu_a), .acc_stb(acc_stb), .hit(hit), .serve_bank(serve_bank),
    .rom_addr(rom_addr), .rom_oe(rom_oe)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import cart_map_pkg::*;
#(
  parameter hot_mode_e   MODE   = SWITCH_FIRST,
  parameter int unsigned BANK_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [12:0]        cpu_a,
  input logic               acc_stb,
  input logic [BANK_W+11:0] rom_addr,
  input logic               rom_oe,
  input logic               hit,
  input logic [BANK_W-1:0]  hit_bank,
  input logic [BANK_W-1:0]  bank_q,
  input logic               prev_hot_q
);
  a_r1_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
    rom_oe |-> (acc_stb && cpu_a[12]));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_stb || !cpu_a[12]) |=> $stable(bank_q));

  a_r8_float_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == FLOAT_BUS && acc_stb && hit) |-> !rom_oe);

  a_r4_edge_new: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == SWITCH_FIRST && acc_stb && hit && !prev_hot_q)
      |-> (rom_addr[BANK_W+11:12] == hit_bank));

  a_r6_level_old: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == FETCH_FIRST && acc_stb && hit && !prev_hot_q)
      |-> (rom_addr[BANK_W+11:12] == bank_q));

  a_r8_float_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == FLOAT_BUS && acc_stb && hit) |=> (bank_q == $past(hit_bank)));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.MODE(MODE), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_a(cpu_a), .acc_stb(acc_stb),
  .rom_addr(rom_addr), .rom_oe(rom_oe), .hit(hit), .hit_bank(hit_bank),
  .bank_q(bank_q), .prev_hot_q(prev_hot_q)
);

// File: tb/tb_cart_bank_mapper.sv
`timescale 1ns/1ps
module tb_cart_bank_mapper;
  import cart_map_pkg::*;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic [12:0] cpu_a = 13'h0000;
  logic        acc_stb = 1'b0;

  logic [14:0] e_addr, l_addr;
  logic [13:0] f_addr;
  logic [12:0] t_addr;
  logic        e_oe, l_oe, f_oe, t_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cart_bank_mapper #(.NUM_BANKS(8), .MODE(SWITCH_FIRST), .RESET_BANK(0)) dut (
    .clk(clk), .arst_n(arst_n), .cpu_a(cpu_a), .acc_stb(acc_stb),
    .rom_addr(e_addr), .rom_oe(e_oe));
  cart_bank_mapper #(.NUM_BANKS(8), .MODE(FETCH_FIRST), .RESET_BANK(0)) dut_lvl (
    .clk(clk), .arst_n(arst_n), .cpu_a(cpu_a), .acc_stb(acc_stb),
    .rom_addr(l_addr), .rom_oe(l_oe));
  cart_bank_mapper #(.NUM_BANKS(4), .MODE(FLOAT_BUS), .RESET_BANK(3)) dut_flt (
    .clk(clk), .arst_n(arst_n), .cpu_a(cpu_a), .acc_stb(acc_stb),
    .rom_addr(f_addr), .rom_oe(f_oe));
  cart_bank_mapper #(.NUM_BANKS(2), .MODE(SWITCH_FIRST), .RESET_BANK(0)) dut_two (
    .clk(clk), .arst_n(arst_n), .cpu_a(cpu_a), .acc_stb(acc_stb),
    .rom_addr(t_addr), .rom_oe(t_oe));

  // {addr, strobe, edge bank, level bank, oe}
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {13'h1000, 1'b1, 3'd0, 3'd0, 1'b1},
    {13'h1FF6, 1'b1, 3'd2, 3'd0, 1'b1},
    {13'h1234, 1'b1, 3'd2, 3'd2, 1'b1},
    {13'h1FF9, 1'b1, 3'd5, 3'd2, 1'b1},
    {13'h1FFB, 1'b1, 3'd5, 3'd2, 1'b1},
    {13'h1FF4, 1'b1, 3'd5, 3'd2, 1'b1},
    {13'h1100, 1'b1, 3'd5, 3'd0, 1'b1},
    {13'h0FF4, 1'b1, 3'd5, 3'd0, 1'b0},
    {13'h1FF4, 1'b0, 3'd5, 3'd0, 1'b0},
    {13'h1000, 1'b1, 3'd5, 3'd0, 1'b1},
    {13'h1FFA, 1'b1, 3'd6, 3'd0, 1'b1},
    {13'h0500, 1'b1, 3'd6, 3'd6, 1'b0},
    {13'h1FF5, 1'b1, 3'd1, 3'd6, 1'b1},
    {13'h1FFF, 1'b1, 3'd1, 3'd1, 1'b1},
    {13'h1FF3, 1'b1, 3'd1, 3'd1, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [12:0] a, input logic s);
    @(negedge clk);
    cpu_a   = a;
    acc_stb = s;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    acc_stb = 1'b0;
    arst_n  = 1'b0;
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R3: reset bank across builds
    step(13'h1000, 1'b1);
    chk(f_addr[13:12] == 2'd3, "R3 float reset bank", int'(f_addr[13:12]), 3);
    chk(t_addr[12] == 1'b0, "R3 two-bank reset bank", int'(t_addr[12]), 0);
    do_reset();

    // table: R4 R5 R6 R7 R9 R10 R1 R2
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20:8], VEC[i][7]);
      chk(e_addr[14:12] == VEC[i][6:4], $sformatf("R4/R5 edge bank row %0d", i),
          int'(e_addr[14:12]), int'(VEC[i][6:4]));
      chk(l_addr[14:12] == VEC[i][3:1], $sformatf("R6/R7 level bank row %0d", i),
          int'(l_addr[14:12]), int'(VEC[i][3:1]));
      chk(e_oe == VEC[i][0] && l_oe == VEC[i][0], $sformatf("R1 oe row %0d", i),
          int'(e_oe), int'(VEC[i][0]));
      chk(e_addr[11:0] == VEC[i][19:8], $sformatf("R10 low bits row %0d", i),
          int'(e_addr[11:0]), int'(VEC[i][19:8]));
    end

    // float build, 4 banks, reset bank 3: R8 R2 R3
    do_reset();
    step(13'h1000, 1'b1);
    chk(f_addr[13:12] == 2'd3 && f_oe, "R3 float bank after reset", int'(f_addr[13:12]), 3);
    step(13'h1FF7, 1'b1);
    chk(!f_oe, "R8 float oe low on hotspot", int'(f_oe), 0);
    step(13'h1000, 1'b1);
    chk(f_addr[13:12] == 2'd1, "R8 float switched", int'(f_addr[13:12]), 1);
    step(13'h1FF6, 1'b1);
    chk(!f_oe, "R8 float run first", int'(f_oe), 0);
    step(13'h1FF9, 1'b1);
    chk(!f_oe, "R8 float run second", int'(f_oe), 0);
    step(13'h1000, 1'b1);
    chk(f_addr[13:12] == 2'd3, "R8 float run last wins", int'(f_addr[13:12]), 3);
    step(13'h1FF5, 1'b1);
    chk(f_oe && f_addr[13:12] == 2'd3, "R2 0x1FF5 not hot in 4-bank", int'(f_addr[13:12]), 3);
    step(13'h1FFA, 1'b1);
    step(13'h1000, 1'b1);
    chk(f_addr[13:12] == 2'd3, "R2 0x1FFA not hot in 4-bank", int'(f_addr[13:12]), 3);

    // two-bank build: R2 R4
    do_reset();
    step(13'h1FF9, 1'b1);
    chk(t_addr[12] == 1'b1 && t_oe, "R2/R4 two-bank 0x1FF9", int'(t_addr[12]), 1);
    step(13'h1000, 1'b1);
    step(13'h1FF4, 1'b1);
    chk(t_addr[12] == 1'b1, "R2 0x1FF4 not hot in 2-bank", int'(t_addr[12]), 1);
    step(13'h1000, 1'b1);
    step(13'h1FF8, 1'b1);
    chk(t_addr[12] == 1'b0, "R2/R4 two-bank 0x1FF8", int'(t_addr[12]), 0);
    step(13'h1000, 1'b0);
    chk(t_addr[12] == 1'b0 && !t_oe, "R9 idle holds bank", int'(t_addr[12]), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule